// File: doc/BRIEF.md
# Dual Edge Input Capture Unit

This block timestamps transitions on two input pins against a 16-bit counter that advances on every clock. Each pin is synchronized and edge-detected. A rising transition loads that pin's rising-time register, and a falling transition loads its falling-time register. There are four capture registers in total.

In narrow mode each register stores one byte of the counter. A shared prescale field chooses which byte-wide window of the counter is taken. In wide mode the second pin is ignored and the second channel's two registers become the upper bytes of channel 0's rising and falling captures, so channel 0 records full 16-bit times.

A global hold option decides what happens when a register that has not been read sees another edge. With hold off, the register takes the newest edge. With hold on, it keeps the first edge. Each register sets a sticky interrupt flag when it loads. Software reaches every register through a byte-wide read/write bus. Reads and writes of the counter follow a fixed byte order.

Top module: `edge_capture_unit`

## Requirements
- R1: The counter resets to 0, increments by one every clock cycle and wraps from 0xFFFF to 0x0000.
- R2: A read of address 0x0 returns the counter's low byte and latches its high byte into a shadow. A read of address 0x1 returns that shadow, so a low-then-high read pair is coherent.
- R3: A write to address 0x0 only buffers the byte and leaves the counter running. A write to address 0x1 loads the counter with {written byte, buffered byte} on that clock edge.
- R4: Suppose a pin changes between clock edges P0 and P1. The captured value is then the counter value present between edges P2 and P3, and it is visible after P3.
- R5: Config register 0x2 has three fields: bit 0 selects wide mode, bits [3:1] hold a prescale n, and bit 4 selects hold. In narrow mode a register captures counter bits [n+7:n].
- R6: Capture registers sit at 0x8 (channel 0 rising), 0x9 (channel 0 falling), 0xA (channel 1 rising) and 0xB (channel 1 falling). A transition of one polarity leaves the other polarity's register unchanged.
- R7: With hold = 0, every qualifying edge overwrites its register, so the most recent edge time is read.
- R8: With hold = 1, a register keeps its first edge time and ignores later edges until it is read. After the read it accepts the next edge.
- R9: In wide mode, 0x8/0x9 hold the low byte and 0xA/0xB hold the high byte of channel 0's 16-bit rising/falling times, both loaded on the same edge. Pin 1 is ignored. Only a read of the low-byte register releases hold for both halves.
- R10: Flag register 0x4 bit k is set when capture register 0x8+k loads. The flag stays set until 1 is written to that bit. The irq[k] output equals flag k AND enable bit k of register 0x3.
- R11: In wide mode only flags 0 and 1 are set. Flags 2 and 3 stay clear.
- R12: After reset, the config, enable and flag registers and all capture registers read 0, and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_pin | input | 2 | Asynchronous capture inputs, one per channel |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects on the clock edge) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| irq | output | 4 | Per-register interrupt requests |

## Verification
The properties assume that the bus performs at most one access per cycle and uses only mapped addresses. They also assume that each capture pin holds its level longer than the synchronizer and edge-detect depth, so one transition yields exactly one event. The bench enforces this. Every bus access spans a single cycle, and after each pin transition it waits at least four cycles before the next transition or read. It also keeps both pins low through reset, so no spurious edge appears when reset is released.

// File: rtl/ecu_pkg.sv
package ecu_pkg;
   // Register address map
   localparam int A_CNT_LO   = 0;
   localparam int A_CNT_HI   = 1;
   localparam int A_CFG      = 2;
   localparam int A_IEN      = 3;
   localparam int A_FLAG     = 4;
   localparam int A_CAP_BASE = 8;

   // Capture register index within a channel
   typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_kind_e;
endpackage

// File: rtl/ecu_edge_detect.sv
module ecu_edge_detect #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign rise = sync_q[STAGES-1] & ~last_q;
   assign fall = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/ecu_free_counter.sv
module ecu_free_counter #(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic              rd_lo,
   input  logic [BYTE_W-1:0] wdata,
   output logic [CNT_W-1:0]  count,
   output logic [BYTE_W-1:0] shadow_hi
);
   logic [BYTE_W-1:0] lo_buf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count     <= '0;
         lo_buf    <= '0;
         shadow_hi <= '0;
      end else begin
         if (wr_hi) count <= {wdata, lo_buf};
         else       count <= count + 1'b1;
         if (wr_lo) lo_buf <= wdata;
         if (rd_lo) shadow_hi <= count[CNT_W-1:BYTE_W];
      end
   end
endmodule

// File: rtl/ecu_capture_slot.sv
module ecu_capture_slot #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         hold,
   input  logic         clr,
   input  logic [W-1:0] din,
   output logic [W-1:0] q,
   output logic         full,
   output logic         taken
);
   assign taken = load & ~(hold & full);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q    <= '0;
         full <= 1'b0;
      end else begin
         if (clr) full <= 1'b0;
         if (taken) begin
            q    <= din;
            full <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
   import ecu_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cap_pin,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   output logic [3:0]        irq
);
   localparam int NUM_CH     = 2;
   localparam int NUM_REG    = 2 * NUM_CH;
   localparam int SLICE_SPAN = CNT_W - BYTE_W;
   localparam int PS_W       = $clog2(SLICE_SPAN);

   // Elaboration-time parameter checks
   if (CNT_W != 2 * BYTE_W) begin : g_bad_width
      $error("CNT_W must be twice BYTE_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if ((1 << ADDR_W) < A_CAP_BASE + NUM_REG) begin : g_bad_addr
      $error("ADDR_W too small for register map");
   end
   if (PS_W + 2 > BYTE_W) begin : g_bad_cfg
      $error("config fields do not fit in one byte");
   end

   // Configuration state
   logic              cfg_wide;
   logic              cfg_hold;
   logic [PS_W-1:0]   cfg_ps;
   logic [NUM_REG-1:0] irq_en;
   logic [NUM_REG-1:0] flags;

   // Bus decode
   logic wr_cnt_lo, wr_cnt_hi, rd_cnt_lo, wr_cfg, wr_ien, wr_flag;
   logic [NUM_REG-1:0] rd_hit;

   assign wr_cnt_lo = bus_wr && bus_addr == ADDR_W'(A_CNT_LO);
   assign wr_cnt_hi = bus_wr && bus_addr == ADDR_W'(A_CNT_HI);
   assign rd_cnt_lo = bus_rd && bus_addr == ADDR_W'(A_CNT_LO);
   assign wr_cfg    = bus_wr && bus_addr == ADDR_W'(A_CFG);
   assign wr_ien    = bus_wr && bus_addr == ADDR_W'(A_IEN);
   assign wr_flag   = bus_wr && bus_addr == ADDR_W'(A_FLAG);

   // Counter
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] cnt_shadow;

   ecu_free_counter #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_lo     (wr_cnt_lo),
      .wr_hi     (wr_cnt_hi),
      .rd_lo     (rd_cnt_lo),
      .wdata     (bus_wdata),
      .count     (cnt),
      .shadow_hi (cnt_shadow)
   );

   // Prescaled window of the counter
   logic [CNT_W-1:0]  cnt_shifted;
   logic [BYTE_W-1:0] slice;
   assign cnt_shifted = cnt >> cfg_ps;
   assign slice       = cnt_shifted[BYTE_W-1:0];

   // Edge detection per channel; event k = 2*ch + edge kind
   logic [NUM_REG-1:0] ev;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic rise_w, fall_w;
      ecu_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
         .clk   (clk),
         .rst_n (rst_n),
         .pin   (cap_pin[ch]),
         .rise  (rise_w),
         .fall  (fall_w)
      );
      assign ev[2*ch + int'(EDGE_RISE)] = rise_w;
      assign ev[2*ch + int'(EDGE_FALL)] = fall_w;
   end

   // Capture registers
   logic [NUM_REG-1:0][BYTE_W-1:0] cap_q;
   logic [NUM_REG-1:0][BYTE_W-1:0] cap_din;
   logic [NUM_REG-1:0] cap_load, cap_hold, cap_clr, cap_full, cap_taken, flag_set;

   for (genvar k = 0; k < NUM_REG; k++) begin : g_reg
      assign rd_hit[k] = bus_rd && bus_addr == ADDR_W'(A_CAP_BASE + k);

      if (k < 2) begin : g_low
         // Channel 0: low byte in wide mode, window otherwise
         assign cap_load[k] = ev[k];
         assign cap_din[k]  = cfg_wide ? cnt[BYTE_W-1:0] : slice;
         assign cap_hold[k] = cfg_hold;
         assign cap_clr[k]  = rd_hit[k];
         assign flag_set[k] = cap_taken[k];
      end else begin : g_high
         // Channel 1: borrowed as channel 0 high byte in wide mode
         assign cap_load[k] = cfg_wide ? (ev[k-2] & ~(cfg_hold & cap_full[k-2]))
                                       : ev[k];
         assign cap_din[k]  = cfg_wide ? cnt[CNT_W-1:BYTE_W] : slice;
         assign cap_hold[k] = cfg_wide ? 1'b0 : cfg_hold;
         assign cap_clr[k]  = cfg_wide ? rd_hit[k-2] : rd_hit[k];
         assign flag_set[k] = cap_taken[k] & ~cfg_wide;
      end

      ecu_capture_slot #(.W(BYTE_W)) u_slot (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (cap_load[k]),
         .hold  (cap_hold[k]),
         .clr   (cap_clr[k]),
         .din   (cap_din[k]),
         .q     (cap_q[k]),
         .full  (cap_full[k]),
         .taken (cap_taken[k])
      );
   end

   // Control registers and sticky flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_wide <= 1'b0;
         cfg_hold <= 1'b0;
         cfg_ps   <= '0;
         irq_en   <= '0;
         flags    <= '0;
      end else begin
         if (wr_cfg) begin
            cfg_wide <= bus_wdata[0];
            cfg_ps   <= bus_wdata[PS_W:1];
            cfg_hold <= bus_wdata[PS_W+1];
         end
         if (wr_ien) irq_en <= bus_wdata[NUM_REG-1:0];
         flags <= (flags & ~(wr_flag ? bus_wdata[NUM_REG-1:0] : '0)) | flag_set;
      end
   end

   assign irq = flags & irq_en;

   // Read mux
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(A_CNT_LO): bus_rdata = cnt[BYTE_W-1:0];
         ADDR_W'(A_CNT_HI): bus_rdata = cnt_shadow;
         ADDR_W'(A_CFG):    bus_rdata = BYTE_W'({cfg_hold, cfg_ps, cfg_wide});
         ADDR_W'(A_IEN):    bus_rdata = BYTE_W'(irq_en);
         ADDR_W'(A_FLAG):   bus_rdata = BYTE_W'(flags);
         default:           bus_rdata = '0;
      endcase
      for (int k = 0; k < NUM_REG; k++) begin
         if (bus_addr == ADDR_W'(A_CAP_BASE + k)) bus_rdata = cap_q[k];
      end
   end
endmodule

// File: rtl/ecu_checker.sv
module ecu_checker
   import ecu_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   bus_wr,
   input logic [ADDR_W-1:0]      bus_addr,
   input logic [BYTE_W-1:0]      bus_wdata,
   input logic [CNT_W-1:0]       cnt,
   input logic [3:0]             flags,
   input logic                   cfg_wide,
   input logic                   cfg_hold,
   input logic [3:0][BYTE_W-1:0] cap_q,
   input logic [3:0]             cap_full,
   input logic [3:0]             rd_hit
);
   logic seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   // R1
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && !(bus_wr && bus_addr == ADDR_W'(A_CNT_HI)))
         |=> (cnt == $past(cnt) + 1'b1));

   for (genvar k = 0; k < 4; k++) begin : g_flag
      // R10
      flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[k] && !(bus_wr && bus_addr == ADDR_W'(A_FLAG) && bus_wdata[k]))
            |=> flags[k]);
   end

   for (genvar k = 2; k < 4; k++) begin : g_wide
      // R11
      wide_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_wide && !flags[k]) |=> !flags[k]);
   end

   for (genvar k = 0; k < 2; k++) begin : g_hold
      // R8
      hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_hold && cap_full[k] && !rd_hit[k]) |=> $stable(cap_q[k]));
   end
endmodule

bind edge_capture_unit ecu_checker #(
   .CNT_W(CNT_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .cnt       (cnt),
   .flags     (flags),
   .cfg_wide  (cfg_wide),
   .cfg_hold  (cfg_hold),
   .cap_q     (cap_q),
   .cap_full  (cap_full),
   .rd_hit    (rd_hit)
);

// File: tb/edge_capture_unit_test.sv
`timescale 1ns/1ps
module edge_capture_unit_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cap_pin = 2'b00;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [3:0] irq;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   edge_capture_unit uut (
      .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // All tasks start and end just after a falling edge
   task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk); @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic expect_reg(input string req, input logic [3:0] a, input logic [7:0] exp);
      logic [7:0] d;
      bus_read(a, d);
      check(req, {8'h00, d}, {8'h00, exp});
   endtask

   task automatic set_counter(input logic [15:0] v);
      bus_write(4'h0, v[7:0]);
      bus_write(4'h1, v[15:8]);
   endtask

   // Pin change right after the counter is set to v: captured time is v+2
   task automatic pin_edge(input int ch, input logic lvl, input logic [15:0] v);
      set_counter(v);
      cap_pin[ch] = lvl;
      repeat (4) @(negedge clk);
   endtask

   function automatic logic [7:0] window(input logic [15:0] v, input int n);
      logic [15:0] s;
      s = v >> n;
      return s[7:0];
   endfunction

   task automatic t_reset();
      expect_reg("R12 cfg", 4'h2, 8'h00);
      expect_reg("R12 ien", 4'h3, 8'h00);
      expect_reg("R12 flags", 4'h4, 8'h00);
      for (int k = 0; k < 4; k++) expect_reg("R12 capture", 4'(8 + k), 8'h00);
      check("R12 irq", {12'h0, irq}, 16'h0);
   endtask

   task automatic t_counter();
      logic [7:0] d;
      set_counter(16'h0010);
      repeat (3) @(negedge clk);
      expect_reg("R1 increment", 4'h0, 8'h13);
      set_counter(16'h12FF);
      expect_reg("R2 low byte", 4'h0, 8'hFF);
      expect_reg("R2 shadow high", 4'h1, 8'h12);
      set_counter(16'hFFFF);
      @(negedge clk);
      expect_reg("R1 wrap low", 4'h0, 8'h00);
      expect_reg("R1 wrap high", 4'h1, 8'h00);
      set_counter(16'h1000);
      bus_write(4'h0, 8'h77);
      expect_reg("R3 low write buffered", 4'h0, 8'h01);
      bus_write(4'h1, 8'h55);
      bus_read(4'h0, d);
      check("R3 load low", {8'h0, d}, 16'h0077);
      expect_reg("R3 load high", 4'h1, 8'h55);
   endtask

   task automatic t_capture_basic();
      bus_write(4'h2, 8'h00);
      pin_edge(0, 1'b1, 16'h0140);
      expect_reg("R4 rise latency", 4'h8, 8'h42);
      pin_edge(0, 1'b0, 16'h0200);
      expect_reg("R6 fall register", 4'h9, 8'h02);
      expect_reg("R6 rise untouched", 4'h8, 8'h42);
      pin_edge(1, 1'b1, 16'h0310);
      expect_reg("R6 channel1 rise", 4'hA, 8'h12);
   endtask

   task automatic t_recent();
      pin_edge(0, 1'b1, 16'h0050);
      pin_edge(0, 1'b0, 16'h0055);
      pin_edge(0, 1'b1, 16'h0060);
      expect_reg("R7 most recent", 4'h8, 8'h62);
   endtask

   task automatic t_prescale();
      bus_write(4'h2, 8'h0A);   // n = 5
      pin_edge(0, 1'b0, 16'h1000);
      pin_edge(0, 1'b1, 16'h1234);
      expect_reg("R5 prescale 5", 4'h8, window(16'h1236, 5));
      bus_write(4'h2, 8'h0E);   // n = 7
      pin_edge(0, 1'b0, 16'h2000);
      pin_edge(0, 1'b1, 16'hFFF0);
      expect_reg("R5 prescale 7", 4'h8, window(16'hFFF2, 7));
   endtask

   task automatic t_hold();
      logic [7:0] d;
      bus_write(4'h2, 8'h10);
      bus_read(4'h8, d);
      pin_edge(0, 1'b0, 16'h0400);
      pin_edge(0, 1'b1, 16'h0420);
      pin_edge(0, 1'b0, 16'h0500);
      pin_edge(0, 1'b1, 16'h0530);
      expect_reg("R8 first edge kept", 4'h8, 8'h22);
      pin_edge(0, 1'b0, 16'h0600);
      pin_edge(0, 1'b1, 16'h0640);
      expect_reg("R8 released by read", 4'h8, 8'h42);
   endtask

   task automatic t_irq();
      bus_write(4'h2, 8'h00);
      bus_write(4'h4, 8'h0F);
      bus_write(4'h3, 8'h01);
      pin_edge(0, 1'b0, 16'h0700);
      pin_edge(0, 1'b1, 16'h0710);
      expect_reg("R10 flags set", 4'h4, 8'h03);
      check("R10 irq masked", {12'h0, irq}, 16'h0001);
      bus_write(4'h4, 8'h01);
      expect_reg("R10 write one clears", 4'h4, 8'h02);
      check("R10 irq after clear", {12'h0, irq}, 16'h0000);
   endtask

   task automatic t_wide();
      logic [7:0] d;
      bus_write(4'h4, 8'h0F);
      bus_write(4'h2, 8'h01);
      pin_edge(0, 1'b0, 16'h2000);
      pin_edge(0, 1'b1, 16'hAB10);
      expect_reg("R9 wide low byte", 4'h8, 8'h12);
      expect_reg("R9 wide high byte", 4'hA, 8'hAB);
      pin_edge(1, 1'b0, 16'h3300);
      expect_reg("R9 pin1 ignored", 4'hB, 8'h20);
      expect_reg("R11 only channel0 flags", 4'h4, 8'h03);
      bus_write(4'h2, 8'h11);
      pin_edge(0, 1'b0, 16'h4000);
      pin_edge(0, 1'b1, 16'hC100);
      bus_read(4'hA, d);
      check("R9 wide hold first high", {8'h0, d}, 16'h00C1);
      pin_edge(0, 1'b0, 16'h4100);
      pin_edge(0, 1'b1, 16'hD100);
      expect_reg("R9 high read keeps hold", 4'hA, 8'hC1);
      expect_reg("R9 low byte held", 4'h8, 8'h02);
      pin_edge(0, 1'b0, 16'h4200);
      pin_edge(0, 1'b1, 16'hE100);
      expect_reg("R9 low read releases both", 4'hA, 8'hE1);
   endtask

   initial begin
      #1_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_counter();
      t_capture_basic();
      t_recent();
      t_prescale();
      t_hold();
      t_irq();
      t_wide();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule